// File: doc/BRIEF.md
# Composite Blanking Pulse Generator

This block produces a per-clock level code for a composite blanking signal on a display deflection path. Every line it places a burst key at a fixed position after line start. It then adds a horizontal blanking interval and, optionally, a vertical blanking contribution. A later analog stage turns the 2-bit code into voltage levels; that stage is not part of this block.

The horizontal blanking interval has three timing sources. In the default mode it follows the live flyback input. In the alignment mode a window is computed from register fields and counted in line-locked clock cycles. In the third mode all blanking is suppressed. A separate switch chooses whether vertical blanking appears on the output or only horizontal blanking is ever emitted. The mode, switch and field inputs are sampled only at line start, so each line runs on one coherent setting.

The alignment window is produced by a four-state machine:
- `S_IDLE`: the state after reset, left only on a line start.
- `S_LEAD`: counting down the start offset.
- `S_BLANK`: counting down the window width.
- `S_TAIL`: the rest of the line.

Its transitions are:
- line start → `S_LEAD` (offset > 0), `S_BLANK` (offset = 0) or `S_TAIL` (window disabled).
- `S_LEAD` → `S_BLANK` when the offset count expires.
- `S_BLANK` → `S_TAIL` when the width count expires.

A line start overrides every state.

Top module: `cbp_blank_gen`

## Requirements
- R1: After reset, and before the first line start, the code is 0 (none) with flyback and vblank low. No burst appears. The default setting applies: flyback mode with vertical blanking included, so flyback high gives 2 and vblank high alone gives 3.
- R2: Position 0 is the clock cycle after the edge that samples `line_start` high. The burst code 1 is output at positions BURST_START to BURST_START+BURST_LEN-1 (defaults 20 to 29).
- R3: With `cfg_blank_off`=0 and `cfg_align_mode`=0, the code is 2 (H-blank) whenever `flyback` is high, outside the burst.
- R4: With `cfg_blank_off`=0 and `cfg_align_mode`=1, the H-blank window lasts 4·`cfg_width`+1 cycles. In this mode `flyback` is ignored.
- R5: In alignment mode the window starts at position `cfg_hshift` + 4·`cfg_phase` − 2·`cfg_width` + 45, with a result below 0 taken as 0.
- R6: With `cfg_blank_off`=1, codes 2 and 3 never appear, whatever `flyback` and `vblank` do. The burst is still output.
- R7: With `cfg_hblank_only`=0 and blanking enabled, the code is 3 (V-blank) while `vblank` is high and neither burst nor H-blank is active.
- R8: With `cfg_hblank_only`=1, code 3 never appears and `vblank` has no effect.
- R9: Priority is burst over H-blank over V-blank.
- R10: The mode, switch and field inputs take effect only at a line start. A change in mid-line leaves the running line unchanged.
- R11: A line start that arrives during a window restarts position counting and window timing from position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle pulse marking the start of a line |
| flyback | input | 1 | Horizontal flyback active |
| vblank | input | 1 | Vertical blanking period active |
| cfg_blank_off | input | 1 | Suppress all blanking |
| cfg_align_mode | input | 1 | Use the computed window instead of flyback |
| cfg_hblank_only | input | 1 | Exclude vertical blanking from the output |
| cfg_hshift | input | SHIFT_W | Horizontal shift term of the start offset |
| cfg_phase | input | PHASE_W | Phase term, weighted by 4 in the offset |
| cfg_width | input | TIME_W | Width field; sets the width and enters the offset |
| blank_code | output | 2 | 0 none, 1 burst, 2 H-blank, 3 V-blank |

## Verification
The block is exercised with the following patterns:
- Flyback pulses placed both clear of the burst and across it. These separate live flyback following from the priority of the burst.
- Alignment settings whose windows fall after the burst and settings whose windows cover it. These confirm the width and offset arithmetic cycle by cycle and show which code wins.
- Vertical blanking held high under both settings of the switch, and under suppression. This shows whether V-blank only fills the gaps or is removed.
- Settings changed in mid-line, and line starts sent in the middle of a window. These tell a correct line-start latch and restart apart from designs that react at once or keep the old count.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    typedef enum logic [1:0] {
        CODE_NONE   = 2'd0,
        CODE_BURST  = 2'd1,
        CODE_HBLANK = 2'd2,
        CODE_VBLANK = 2'd3
    } code_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_LEAD  = 2'd1,
        S_BLANK = 2'd2,
        S_TAIL  = 2'd3
    } hwin_state_e;

endpackage

// File: rtl/cbp_cfg_latch.sv
module cbp_cfg_latch #(
    parameter int SHIFT_W = 6,
    parameter int PHASE_W = 4,
    parameter int TIME_W  = 4,
    parameter int OFS_W   = 8,
    parameter int WID_W   = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               cfg_blank_off,
    input  logic               cfg_align_mode,
    input  logic               cfg_hblank_only,
    input  logic [SHIFT_W-1:0] cfg_hshift,
    input  logic [PHASE_W-1:0] cfg_phase,
    input  logic [TIME_W-1:0]  cfg_width,
    output logic [OFS_W-1:0]   ofs_d,
    output logic [WID_W-1:0]   wid_d,
    output logic               win_en_d,
    output logic [WID_W-1:0]   wid_q,
    output logic               blank_off_q,
    output logic               align_q,
    output logic               honly_q
);

    int ofs_i;

    // Offset arithmetic on the incoming fields; negative results clamp to 0.
    always_comb begin
        ofs_i = int'(cfg_hshift) + 4 * int'(cfg_phase) - 2 * int'(cfg_width) + 45;
        if (ofs_i < 0) begin
            ofs_d = '0;
        end else begin
            ofs_d = OFS_W'(ofs_i);
        end
        wid_d    = WID_W'(4 * int'(cfg_width) + 1);
        win_en_d = cfg_align_mode && !cfg_blank_off;
    end

    // Settings held for a whole line.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wid_q       <= WID_W'(1);
            blank_off_q <= 1'b0;
            align_q     <= 1'b0;
            honly_q     <= 1'b0;
        end else if (line_start) begin
            wid_q       <= wid_d;
            blank_off_q <= cfg_blank_off;
            align_q     <= cfg_align_mode;
            honly_q     <= cfg_hblank_only;
        end
    end

endmodule

// File: rtl/cbp_hwin_fsm.sv
module cbp_hwin_fsm
    import cbp_pkg::*;
#(
    parameter int OFS_W = 8,
    parameter int WID_W = 6,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_start,
    input  logic             win_en_d,
    input  logic [OFS_W-1:0] ofs_d,
    input  logic [WID_W-1:0] wid_d,
    input  logic [WID_W-1:0] wid_q,
    output logic             hwin
);

    hwin_state_e      st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next state; a line start overrides every state.
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (line_start) begin
            if (!win_en_d) begin
                st_d = S_TAIL;
            end else if (ofs_d == '0) begin
                st_d  = S_BLANK;
                cnt_d = CNT_W'(wid_d) - CNT_W'(1);
            end else begin
                st_d  = S_LEAD;
                cnt_d = CNT_W'(ofs_d) - CNT_W'(1);
            end
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    st_d = S_IDLE;
                end
                S_LEAD: begin
                    if (cnt_q == '0) begin
                        st_d  = S_BLANK;
                        cnt_d = CNT_W'(wid_q) - CNT_W'(1);
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                S_BLANK: begin
                    if (cnt_q == '0) begin
                        st_d = S_TAIL;
                    end else begin
                        cnt_d = cnt_q - CNT_W'(1);
                    end
                end
                S_TAIL: begin
                    st_d = S_TAIL;
                end
            endcase
        end
    end

    // Outputs.
    always_comb begin
        hwin = (st_q == S_BLANK);
    end

endmodule

// File: rtl/cbp_burst_gen.sv
module cbp_burst_gen #(
    parameter int POS_W       = 11,
    parameter int BURST_START = 20,
    parameter int BURST_LEN   = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    output logic burst_key
);

    localparam logic [POS_W-1:0] KEY_LO = POS_W'(BURST_START);
    localparam logic [POS_W-1:0] KEY_HI = POS_W'(BURST_START + BURST_LEN);

    logic [POS_W-1:0] pos_q;
    logic             started_q;

    // Position since line start, saturating at its top value.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q     <= '0;
            started_q <= 1'b0;
        end else if (line_start) begin
            pos_q     <= '0;
            started_q <= 1'b1;
        end else if (pos_q != '1) begin
            pos_q <= pos_q + POS_W'(1);
        end
    end

    always_comb begin
        burst_key = started_q && (pos_q >= KEY_LO) && (pos_q < KEY_HI);
    end

endmodule

// File: rtl/cbp_blank_gen.sv
module cbp_blank_gen
    import cbp_pkg::*;
#(
    parameter int SHIFT_W     = 6,
    parameter int PHASE_W     = 4,
    parameter int TIME_W      = 4,
    parameter int POS_W       = 11,
    parameter int BURST_START = 20,
    parameter int BURST_LEN   = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_start,
    input  logic               flyback,
    input  logic               vblank,
    input  logic               cfg_blank_off,
    input  logic               cfg_align_mode,
    input  logic               cfg_hblank_only,
    input  logic [SHIFT_W-1:0] cfg_hshift,
    input  logic [PHASE_W-1:0] cfg_phase,
    input  logic [TIME_W-1:0]  cfg_width,
    output logic [1:0]         blank_code
);

    localparam int OFS_MAX = (2**SHIFT_W - 1) + 4 * (2**PHASE_W - 1) + 45;
    localparam int OFS_W   = $clog2(OFS_MAX + 1);
    localparam int WID_W   = $clog2(4 * (2**TIME_W - 1) + 2);
    localparam int CNT_W   = (OFS_W > WID_W) ? OFS_W : WID_W;

    logic [OFS_W-1:0] ofs_d;
    logic [WID_W-1:0] wid_d;
    logic [WID_W-1:0] wid_q;
    logic             win_en_d;
    logic             blank_off_q;
    logic             align_q;
    logic             honly_q;
    logic             hwin;
    logic             burst_key;
    code_e            code;

    cbp_cfg_latch #(
        .SHIFT_W (SHIFT_W),
        .PHASE_W (PHASE_W),
        .TIME_W  (TIME_W),
        .OFS_W   (OFS_W),
        .WID_W   (WID_W)
    ) u_cfg (
        .clk             (clk),
        .rst_n           (rst_n),
        .line_start      (line_start),
        .cfg_blank_off   (cfg_blank_off),
        .cfg_align_mode  (cfg_align_mode),
        .cfg_hblank_only (cfg_hblank_only),
        .cfg_hshift      (cfg_hshift),
        .cfg_phase       (cfg_phase),
        .cfg_width       (cfg_width),
        .ofs_d           (ofs_d),
        .wid_d           (wid_d),
        .win_en_d        (win_en_d),
        .wid_q           (wid_q),
        .blank_off_q     (blank_off_q),
        .align_q         (align_q),
        .honly_q         (honly_q)
    );

    cbp_hwin_fsm #(
        .OFS_W (OFS_W),
        .WID_W (WID_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .win_en_d   (win_en_d),
        .ofs_d      (ofs_d),
        .wid_d      (wid_d),
        .wid_q      (wid_q),
        .hwin       (hwin)
    );

    cbp_burst_gen #(
        .POS_W       (POS_W),
        .BURST_START (BURST_START),
        .BURST_LEN   (BURST_LEN)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .burst_key  (burst_key)
    );

    // Level selection: burst, then H-blank, then V-blank.
    always_comb begin
        code = CODE_NONE;
        if (burst_key) begin
            code = CODE_BURST;
        end else if (!blank_off_q && (align_q ? hwin : flyback)) begin
            code = CODE_HBLANK;
        end else if (!blank_off_q && !honly_q && vblank) begin
            code = CODE_VBLANK;
        end
    end

    assign blank_code = code;

endmodule

// File: rtl/cbp_blank_gen_chk.sv
module cbp_blank_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       line_start,
    input logic       flyback,
    input logic       burst_key,
    input logic       hwin,
    input logic       blank_off_q,
    input logic       align_q,
    input logic       honly_q,
    input logic [1:0] blank_code
);

    AST_BURST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        burst_key |-> blank_code == 2'd1); // R9

    AST_OFF_NO_BLANK: assert property (@(posedge clk) disable iff (!rst_n)
        blank_off_q |-> blank_code <= 2'd1); // R6

    AST_HONLY_NO_VBLANK: assert property (@(posedge clk) disable iff (!rst_n)
        honly_q |-> blank_code != 2'd3); // R8

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable({blank_off_q, align_q, honly_q})); // R10

    AST_WIN_ALIGN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        hwin |-> (align_q && !blank_off_q)); // R4

    AST_HBLANK_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        blank_code == 2'd2 |-> (hwin || (!align_q && flyback))); // R3

endmodule

bind cbp_blank_gen cbp_blank_gen_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_start  (line_start),
    .flyback     (flyback),
    .burst_key   (burst_key),
    .hwin        (hwin),
    .blank_off_q (blank_off_q),
    .align_q     (align_q),
    .honly_q     (honly_q),
    .blank_code  (blank_code)
);

// File: tb/test_cbp_blank_gen.sv
module test_cbp_blank_gen;

    localparam int BS = 20;
    localparam int BL = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_start = 1'b0;
    logic       flyback = 1'b0;
    logic       vblank = 1'b0;
    logic       cfg_blank_off = 1'b0;
    logic       cfg_align_mode = 1'b0;
    logic       cfg_hblank_only = 1'b0;
    logic [5:0] cfg_hshift = '0;
    logic [3:0] cfg_phase = '0;
    logic [3:0] cfg_width = '0;
    logic [1:0] blank_code;

    int checks = 0;
    int failures = 0;

    // Bench model of the setting in force for the current line.
    logic m_started = 1'b0;
    logic m_bo = 1'b0;
    logic m_al = 1'b0;
    logic m_ho = 1'b0;
    int   m_off = 0;
    int   m_wid = 1;
    int   pos_b = 0;

    always #2.5 clk = ~clk;

    cbp_blank_gen #(.BURST_START(BS), .BURST_LEN(BL)) i_cbp_blank_gen (
        .clk             (clk),
        .rst_n           (rst_n),
        .line_start      (line_start),
        .flyback         (flyback),
        .vblank          (vblank),
        .cfg_blank_off   (cfg_blank_off),
        .cfg_align_mode  (cfg_align_mode),
        .cfg_hblank_only (cfg_hblank_only),
        .cfg_hshift      (cfg_hshift),
        .cfg_phase       (cfg_phase),
        .cfg_width       (cfg_width),
        .blank_code      (blank_code)
    );

    function automatic logic [1:0] expect_code(input int p, input logic fly, input logic vb);
        if (m_started && p >= BS && p < BS + BL) return 2'd1;
        if (!m_bo) begin
            if (m_al ? (m_started && p >= m_off && p < m_off + m_wid) : fly) return 2'd2;
            if (!m_ho && vb) return 2'd3;
        end
        return 2'd0;
    endfunction

    task automatic check_code(input logic [1:0] exp, input string tag);
        checks++;
        if (blank_code !== exp) begin
            failures++;
            $display("FAIL %s pos=%0d got=%0d exp=%0d", tag, pos_b, blank_code, exp);
        end
    endtask

    task automatic start_line(input logic bo, input logic al, input logic ho,
                              input int sh, input int ph, input int tm);
        @(negedge clk);
        cfg_blank_off   = bo;
        cfg_align_mode  = al;
        cfg_hblank_only = ho;
        cfg_hshift      = 6'(sh);
        cfg_phase       = 4'(ph);
        cfg_width       = 4'(tm);
        line_start      = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        m_started  = 1'b1;
        m_bo       = bo;
        m_al       = al;
        m_ho       = ho;
        m_off      = sh + 4 * ph - 2 * tm + 45;
        if (m_off < 0) m_off = 0;
        m_wid      = 4 * tm + 1;
        pos_b      = 0;
    endtask

    task automatic run_cycles(input int n, input logic fly, input logic vb, input string tag);
        for (int i = 0; i < n; i++) begin
            flyback = fly;
            vblank  = vb;
            #1;
            check_code(expect_code(pos_b, fly, vb), tag);
            pos_b++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        run_cycles(30, 1'b0, 1'b0, "R1 idle none");
        run_cycles(3, 1'b0, 1'b1, "R1 default vblank");
        run_cycles(3, 1'b1, 1'b1, "R1 default flyback");
    endtask

    task automatic t_flyback;
        start_line(1'b0, 1'b0, 1'b0, 0, 0, 0);
        run_cycles(12, 1'b0, 1'b0, "R2 none before burst");
        run_cycles(6, 1'b1, 1'b0, "R3 flyback hblank");
        run_cycles(15, 1'b1, 1'b0, "R9 burst over flyback");
        run_cycles(10, 1'b0, 1'b0, "R3 flyback low");
    endtask

    task automatic t_align;
        start_line(1'b0, 1'b1, 1'b0, 5, 3, 2);
        run_cycles(80, 1'b1, 1'b0, "R4 R5 window 58..66");
        start_line(1'b0, 1'b1, 1'b0, 0, 0, 15);
        run_cycles(90, 1'b0, 1'b0, "R9 window covers burst");
        start_line(1'b0, 1'b1, 1'b0, 63, 15, 0);
        run_cycles(175, 1'b0, 1'b0, "R5 max offset");
    endtask

    task automatic t_vblank;
        start_line(1'b0, 1'b1, 1'b0, 10, 0, 0);
        run_cycles(70, 1'b0, 1'b1, "R7 vblank fills");
        start_line(1'b0, 1'b1, 1'b1, 10, 0, 0);
        run_cycles(70, 1'b0, 1'b1, "R8 vblank excluded");
        start_line(1'b0, 1'b0, 1'b1, 0, 0, 0);
        run_cycles(10, 1'b0, 1'b1, "R8 flyback mode vblank");
        run_cycles(10, 1'b1, 1'b1, "R8 flyback only");
    endtask

    task automatic t_blank_off;
        start_line(1'b1, 1'b0, 1'b0, 0, 0, 0);
        run_cycles(40, 1'b1, 1'b1, "R6 off flyback mode");
        start_line(1'b1, 1'b1, 1'b0, 0, 0, 15);
        run_cycles(80, 1'b0, 1'b1, "R6 off align mode");
    endtask

    task automatic t_latch;
        start_line(1'b0, 1'b1, 1'b0, 0, 2, 1);
        run_cycles(10, 1'b0, 1'b0, "R10 before change");
        cfg_blank_off   = 1'b1;
        cfg_align_mode  = 1'b0;
        cfg_hblank_only = 1'b1;
        cfg_hshift      = 6'd63;
        cfg_phase       = 4'd15;
        cfg_width       = 4'd15;
        run_cycles(70, 1'b1, 1'b1, "R10 mid-line change ignored");
        start_line(1'b1, 1'b0, 1'b1, 63, 15, 15);
        run_cycles(40, 1'b1, 1'b1, "R10 new line applies");
    endtask

    task automatic t_restart;
        start_line(1'b0, 1'b1, 1'b0, 0, 0, 15);
        run_cycles(30, 1'b0, 1'b0, "R11 first line");
        start_line(1'b0, 1'b1, 1'b0, 0, 0, 15);
        run_cycles(80, 1'b0, 1'b0, "R11 restarted window");
        start_line(1'b0, 1'b1, 1'b0, 5, 3, 2);
        run_cycles(62, 1'b0, 1'b0, "R11 cut inside window");
        start_line(1'b0, 1'b1, 1'b0, 5, 3, 2);
        run_cycles(70, 1'b0, 1'b0, "R11 full window again");
    endtask

    initial begin
        #1000000;
        failures++;
        $display("FAIL watchdog expired checks=%0d", checks);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flyback();
        t_align();
        t_vblank();
        t_blank_off();
        t_latch();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule